// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is a synchronous master for an external memory and I/O bus whose low address byte and data byte share one set of pins. An internal core places a read or write request with `req`. The core holds the address, direction, data-memory select, write data and extended-timing flag stable until `ready` pulses. The block copies these fields when it accepts the request. It then runs one bus cycle: an address phase, an active-low address strobe, a gap, an active-low data strobe, and a recovery phase. Each phase lasts a whole number of clock cycles, and a parameter sets each number.

The bus has no wait-state input, so every read or write takes a fixed number of clock cycles. A read keeps the data strobe low for longer than a write. When the extended-timing flag is set, two more cycles are added to the data-strobe low phase. Read data is taken from the bus at the clock edge on which the data strobe rises. The high address byte is driven on its own dedicated output.

The controller is a six-state machine:
- IDLE moves to ADDR when `req` is high.
- ADDR moves to AS_LOW after one cycle.
- AS_LOW moves to AS_HIGH after `AS_CYC` cycles.
- AS_HIGH moves to DS_LOW after `GAP_CYC` cycles.
- DS_LOW moves to RECOVER after the data-phase length. This is `RD_CYC` or `WR_CYC`, plus `EXT_CYC` when extended timing is set. The same edge captures read data.
- RECOVER moves to IDLE after `REC_CYC` cycles. `ready` is high in the last RECOVER cycle.

Top module: `muxbus_seq`

## Requirements
- R1: While reset is held, `as_n`, `ds_n`, `rw` and `dmem_n` are 1, and `ad_oe` and `ready` are 0.
- R2: A request accepted in IDLE produces one ADDR cycle before `as_n` falls. During that cycle `ad_oe`=1, `ad_o`=addr[7:0], `as_n`=1, `rw`=!we and `dmem_n`=!dm_sel.
- R3: `as_n` stays low for exactly `AS_CYC` cycles. The low address byte is driven on `ad_o` with `ad_oe`=1 throughout.
- R4: `ds_n` falls exactly `GAP_CYC` cycles after `as_n` rises. On a read, `ad_oe` goes to 0 on the same edge on which `ds_n` falls.
- R5: `ds_n` stays low for `RD_CYC` cycles on a read and `WR_CYC` cycles on a write.
- R6: When `ext_tm` is 1 at acceptance, the `ds_n` low time grows by `EXT_CYC` cycles (2 by default).
- R7: On a write, `ad_o` carries wdata with `ad_oe`=1 while `ds_n` is low and through the whole recovery phase.
- R8: `rdata` takes the value of `ad_i` in the last cycle in which `ds_n` is low. Changes on `ad_i` after `ds_n` rises have no effect on `rdata`.
- R9: `rw`, `dmem_n` and `a_hi` stay stable from ADDR until the end of recovery. The next `as_n` fall comes no earlier than `REC_CYC`+2 cycles after `ds_n` rises.
- R10: `ready` is a one-cycle pulse in the last recovery cycle. Changes to request inputs after acceptance do not affect the running cycle.
- R11: `as_n` and `ds_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Core request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| dm_sel | input | 1 | 1 = data memory space |
| ext_tm | input | 1 | Extended data-strobe timing |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Cycle complete pulse |
| rdata | output | 8 | Captured read data |
| ad_o | output | 8 | Shared bus drive value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_i | input | 8 | Shared bus sampled value |
| a_hi | output | 8 | High address byte |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | 1 = read, 0 = write |
| dmem_n | output | 1 | Data-memory select, active low |

## Verification
The hardest case to reach is the minimum spacing between two bus cycles. It only appears when the core keeps `req` high through `ready`, so the state machine goes straight from RECOVER through IDLE into the next ADDR. A dedicated scenario holds the request across the pulse and counts the cycles from the `ds_n` rise to the next `as_n` fall. The exact capture edge is checked with a bus model that drives one value only while `ds_n` is low and the complement at all other times. A capture one cycle late would therefore return the wrong byte.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AS_LOW,
        ST_AS_HIGH,
        ST_DS_LOW,
        ST_RECOVER
    } mb_state_t;

    function automatic int mb_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mb_phase_timer.sv
module mb_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Down-counter: loading N gives N cycles in the phase, done in the last.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len - CW'(1);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/mb_req_latch.sv
module mb_req_latch #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic          dm_sel,
    input  logic          ext_tm,
    input  logic [DW-1:0] wdata,
    input  logic          cap,
    input  logic [DW-1:0] ad_i,
    output logic [AW-1:0] q_addr,
    output logic          q_we,
    output logic          q_dm,
    output logic          q_ext,
    output logic [DW-1:0] q_wdata,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_we    <= 1'b0;
            q_dm    <= 1'b0;
            q_ext   <= 1'b0;
            q_wdata <= '0;
        end else if (take) begin
            q_addr  <= addr;
            q_we    <= we;
            q_dm    <= dm_sel;
            q_ext   <= ext_tm;
            q_wdata <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (cap)
            rdata <= ad_i;
    end
endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int AS_CYC  = 2,
    parameter int GAP_CYC = 1,
    parameter int RD_CYC  = 3,
    parameter int WR_CYC  = 2,
    parameter int EXT_CYC = 2,
    parameter int REC_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic             dm_sel,
    input  logic             ext_tm,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic             ready,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_i,
    output logic [AW-DW-1:0] a_hi,
    output logic             as_n,
    output logic             ds_n,
    output logic             rw,
    output logic             dmem_n
);
    localparam int MAXLEN = mb_max(mb_max(mb_max(AS_CYC, GAP_CYC), REC_CYC),
                                   mb_max(RD_CYC, WR_CYC) + EXT_CYC);
    localparam int CW = $clog2(MAXLEN + 1);

    mb_state_t     st, st_nx;
    logic          ld, tdone, take, cap;
    logic [CW-1:0] ld_len, ds_len;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_wdata;
    logic          q_we, q_dm, q_ext;

    assign take = (st == ST_IDLE) && req;
    assign cap  = (st == ST_DS_LOW) && tdone && !q_we;
    assign ds_len = CW'(q_we ? WR_CYC : RD_CYC) + (q_ext ? CW'(EXT_CYC) : '0);

    mb_req_latch #(.AW(AW), .DW(DW)) u_lat (
        .clk(clk), .rst_n(rst_n), .take(take),
        .addr(addr), .we(we), .dm_sel(dm_sel), .ext_tm(ext_tm), .wdata(wdata),
        .cap(cap), .ad_i(ad_i),
        .q_addr(q_addr), .q_we(q_we), .q_dm(q_dm), .q_ext(q_ext),
        .q_wdata(q_wdata), .rdata(rdata)
    );

    mb_phase_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(ld), .len(ld_len), .done(tdone)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state and phase-length load
    always_comb begin
        st_nx  = st;
        ld     = 1'b0;
        ld_len = '0;
        unique case (st)
            ST_IDLE: if (req) begin
                st_nx = ST_ADDR;    ld = 1'b1; ld_len = CW'(1);
            end
            ST_ADDR: if (tdone) begin
                st_nx = ST_AS_LOW;  ld = 1'b1; ld_len = CW'(AS_CYC);
            end
            ST_AS_LOW: if (tdone) begin
                st_nx = ST_AS_HIGH; ld = 1'b1; ld_len = CW'(GAP_CYC);
            end
            ST_AS_HIGH: if (tdone) begin
                st_nx = ST_DS_LOW;  ld = 1'b1; ld_len = ds_len;
            end
            ST_DS_LOW: if (tdone) begin
                st_nx = ST_RECOVER; ld = 1'b1; ld_len = CW'(REC_CYC);
            end
            ST_RECOVER: if (tdone) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        as_n   = 1'b1;
        ds_n   = 1'b1;
        rw     = 1'b1;
        dmem_n = 1'b1;
        ad_oe  = 1'b0;
        ad_o   = '0;
        ready  = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_ADDR, ST_AS_LOW: begin
                as_n   = (st != ST_AS_LOW);
                rw     = !q_we;
                dmem_n = !q_dm;
                ad_oe  = 1'b1;
                ad_o   = q_addr[DW-1:0];
            end
            ST_AS_HIGH: begin
                rw     = !q_we;
                dmem_n = !q_dm;
                ad_oe  = 1'b1;
                ad_o   = q_we ? q_wdata : q_addr[DW-1:0];
            end
            ST_DS_LOW, ST_RECOVER: begin
                ds_n   = (st != ST_DS_LOW);
                rw     = !q_we;
                dmem_n = !q_dm;
                ad_oe  = q_we;
                ad_o   = q_we ? q_wdata : '0;
                ready  = (st == ST_RECOVER) && tdone;
            end
            default: ;
        endcase
    end

    assign a_hi = q_addr[AW-1:DW];
endmodule

// File: rtl/muxbus_seq_chk.sv
module muxbus_seq_chk #(
    parameter int AS_CYC  = 2,
    parameter int REC_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic as_n,
    input logic ds_n,
    input logic rw,
    input logic ad_oe,
    input logic ready
);
    logic [7:0] as_cnt, ds_gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_cnt <= '0;
            ds_gap <= 8'hff;
        end else begin
            as_cnt <= !as_n ? as_cnt + 8'd1 : 8'd0;
            if (!ds_n)               ds_gap <= 8'd0;
            else if (ds_gap != 8'hff) ds_gap <= ds_gap + 8'd1;
        end
    end

    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!as_n && !ds_n));
    a_r2_addr_before_as: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |-> $past(ad_oe));
    a_r3_as_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n) |-> (int'(as_cnt) >= AS_CYC));
    a_r4_float_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ds_n) && rw) |-> !ad_oe);
    a_r7_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && !rw) |-> ad_oe);
    a_r9_rw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n) |-> $stable(rw));
    a_r9_as_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |-> (int'(ds_gap) >= REC_CYC + 2));
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    a_r10_ready_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (as_n && ds_n));
endmodule

bind muxbus_seq muxbus_seq_chk #(.AS_CYC(AS_CYC), .REC_CYC(REC_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n),
    .rw(rw), .ad_oe(ad_oe), .ready(ready)
);

// File: tb/test_muxbus_seq.sv
module test_muxbus_seq;
    localparam int AS = 2, GAP = 1, RD = 3, WR = 2, EXT = 2, REC = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req = 0, we = 0, dm_sel = 0, ext_tm = 0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0, ad_i = '0;
    logic        ready, ad_oe, as_n, ds_n, rw, dmem_n;
    logic [7:0]  rdata, ad_o, a_hi;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    muxbus_seq #(.AS_CYC(AS), .GAP_CYC(GAP), .RD_CYC(RD), .WR_CYC(WR),
                 .EXT_CYC(EXT), .REC_CYC(REC)) i_muxbus_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .dm_sel(dm_sel),
        .ext_tm(ext_tm), .addr(addr), .wdata(wdata), .ready(ready),
        .rdata(rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .a_hi(a_hi),
        .as_n(as_n), .ds_n(ds_n), .rw(rw), .dmem_n(dmem_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(as_n && ds_n && rw && dmem_n, "R1 strobes idle", {as_n, ds_n, rw, dmem_n}, 15);
        chk(!ad_oe && !ready, "R1 oe/ready low", {ad_oe, ready}, 0);
    endtask

    // One complete bus cycle; inputs are scrambled after acceptance (R10).
    task automatic run_cycle(input bit w, input bit dm, input bit ext,
                             input logic [15:0] a, input logic [7:0] wd,
                             input logic [7:0] rv);
        int t_asf = -1, t_asr = -1, t_dsf = -1, t_dsr = -1, t_rdy = -1;
        int dsl = (w ? WR : RD) + (ext ? EXT : 0);
        @(negedge clk);
        req = 1; we = w; dm_sel = dm; ext_tm = ext; addr = a; wdata = wd; ad_i = ~rv;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i == 1) begin addr = ~a; wdata = ~wd; we = !w; dm_sel = !dm; ext_tm = !ext; end
            if (i == 0)
                chk(ad_oe && ad_o == a[7:0] && as_n && rw == !w && dmem_n == !dm,
                    "R2 address phase", ad_o, a[7:0]);
            if (t_asf < 0 && !as_n) t_asf = i;
            if (t_asf >= 0 && t_asr < 0 && as_n) t_asr = i;
            if (t_asf >= 0 && t_asr < 0)
                chk(ad_oe && ad_o == a[7:0], "R3 address held", ad_o, a[7:0]);
            if (t_dsf < 0 && !ds_n) t_dsf = i;
            if (t_dsf >= 0 && t_dsr < 0 && ds_n) t_dsr = i;
            if (!ds_n && !w) chk(!ad_oe, "R4 bus released", ad_oe, 0);
            if (w && t_dsf >= 0)
                chk(ad_oe && ad_o == wd, "R7 write data", ad_o, wd);
            chk(rw == !w && dmem_n == !dm && a_hi == a[15:8], "R9 lines stable", a_hi, a[15:8]);
            ad_i = !ds_n ? rv : ~rv;
            if (ready) begin t_rdy = i; req = 0; break; end
        end
        chk(t_asf == 1, "R2 as fall", t_asf, 1);
        chk(t_asr - t_asf == AS, "R3 as width", t_asr - t_asf, AS);
        chk(t_dsf - t_asr == GAP, "R4 as-ds gap", t_dsf - t_asr, GAP);
        chk(t_dsr - t_dsf == dsl, ext ? "R6 extended ds width" : "R5 ds width",
            t_dsr - t_dsf, dsl);
        chk(t_rdy == t_dsr + REC - 1, "R10 ready position", t_rdy, t_dsr + REC - 1);
        @(negedge clk);
        chk(!ready && as_n && ds_n && !ad_oe, "R10 ready one cycle", ready, 0);
        if (!w) chk(rdata == rv, "R8 read capture", rdata, rv);
        ad_i = rv ^ 8'h5a;
        @(negedge clk);
        if (!w) chk(rdata == rv, "R8 late bus ignored", rdata, rv);
    endtask

    // Request held across ready: measure ds rise to next as fall (R9).
    task automatic t_back_to_back();
        int t_dsr = -1, t_as2 = -1, falls = 0, rdy = 0;
        bit seen_ds = 0, prev_as = 1;
        @(negedge clk);
        req = 1; we = 0; dm_sel = 1; ext_tm = 0; addr = 16'h1234; ad_i = 8'h00;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (!ds_n) seen_ds = 1;
            if (seen_ds && ds_n && t_dsr < 0) t_dsr = i;
            if (prev_as && !as_n) begin
                falls++;
                if (falls == 2) t_as2 = i;
            end
            prev_as = as_n;
            if (ready) rdy++;
            if (rdy == 2) begin req = 0; break; end
        end
        chk(t_as2 - t_dsr == REC + 2, "R9 back-to-back gap", t_as2 - t_dsr, REC + 2);
        chk(rdy == 2, "R10 two ready pulses", rdy, 2);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R10 act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
        run_cycle(0, 1, 0, 16'hA55C, 8'h00, 8'h3C);
        run_cycle(0, 0, 1, 16'h0F81, 8'h00, 8'hC7);
        run_cycle(1, 1, 0, 16'h7E02, 8'h96, 8'h00);
        run_cycle(1, 0, 1, 16'hFFFF, 8'h01, 8'h00);
        t_back_to_back();
        run_cycle(0, 1, 1, 16'h0000, 8'h00, 8'hFF);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule